// File: doc/BRIEF.md
# Streaming Spectral Magnitude Estimator with Logarithmic Compression

This block sits after a transform engine and turns each complex frequency bin into a small logarithmic magnitude code. Each bin arrives as a pair of 16-bit signed parts. The block folds the vector into the first quadrant by taking absolute values. It then rotates the vector three times, by 45, about 22.5 and about 11.25 degrees. Each rotation turns clockwise when the current imaginary part is zero or positive and counter-clockwise when it is negative, which walks the vector toward the real axis. The remaining real part is scaled once by the reciprocal of the accumulated rotation gain to give a 15-bit magnitude. That magnitude is reduced to a 6-bit code that keeps the dynamic range: the exponent carries the weight and two mantissa bits refine it.

The datapath is a six-register pipeline that takes one bin per clock. Results leave on a valid/ready stream toward an output FIFO. When the consumer holds off, the whole pipeline freezes and the input ready drops, so no bin is lost, duplicated or reordered. At one bin per clock, a frame of 256 bins fits many times over into a 1 ms frame budget.

Top module: `magcomp_top`

## Requirements
- R1: Each input part is replaced by its absolute value before rotation. The most negative value (-32768) is first saturated to 32767, so (-32768, 0) gives the same magnitude as (32767, 0), and a sign change of either part never changes the result.
- R2: The magnitude is the real part left after three sign-steered micro-rotations with tangents 1, 424/1024 and 204/1024, multiplied by 20995/32768 and rounded. For true magnitudes up to 32767 it lies within [0.975*|v| - 3, 1.005*|v| + 3].
- R3: When the scaled estimate exceeds 32767, out_mag saturates to exactly 32767. An example is (32767, 32767).
- R4: out_code = 4*p + t. Here p is the bit index (0..14) of the most significant one of out_mag, and t is the two bits just below it: bit p-1 is the upper bit of t and bit p-2 is the lower bit, with missing positions below bit 0 read as 0.
- R5: A zero input vector gives out_mag = 0 and out_code = 0.
- R6: With out_ready held high, a bin accepted on a rising edge appears with out_valid high after the sixth rising edge, counting the accepting edge as the first. A new bin can be accepted on every edge.
- R7: While out_valid is high and out_ready is low, out_valid, out_mag and out_code hold, in_ready is low and no bin is accepted. The pipeline holds at most six bins, and results leave in input order with none lost or repeated. in_ready is high whenever out_valid is low.
- R8: After reset, out_valid is 0 and in_ready is 1.
- R9: A burst of 256 bins with out_ready high completes within 262 cycles, measured from the cycle before the first acceptance to the last output transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bin present |
| in_ready | output | 1 | Block accepts a bin on this edge |
| in_re | input | 16 | Real part, two's complement |
| in_im | input | 16 | Imaginary part, two's complement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_mag | output | 15 | Unsigned magnitude estimate |
| out_code | output | 6 | Logarithmic magnitude code |

## Verification
The hardest state to reach from the ports is a completely full pipeline frozen by backpressure, with every stage holding a distinct bin. Reaching it needs out_ready held low while the input keeps offering bins. The stimulus does exactly that, then checks that exactly six bins were taken and that the outputs stay frozen. It then releases the consumer and also toggles out_ready in an irregular pattern during a longer stream. The saturation corners come from driving -32768 in both parts and at full scale, and a sweep of angles around the circle exercises both rotation directions in every stage.

// File: rtl/magcomp_pkg.sv
package magcomp_pkg;

    // Shared configuration of the magnitude estimator.
    localparam int IN_W      = 16;              // signed input part width
    localparam int GUARD     = 3;               // fractional guard bits in the rotator
    localparam int IW        = IN_W + GUARD + 4; // internal signed vector width
    localparam int MAG_W     = 15;              // magnitude output width
    localparam int CODE_W    = 6;               // log code width
    localparam int POS_W     = CODE_W - 2;      // exponent field of the code
    localparam int N_ROT     = 3;               // micro-rotation count
    localparam int TAN_FRAC  = 10;              // fraction bits of tangent constants
    localparam int GAIN_FRAC = 15;              // fraction bits of gain constant
    localparam int GAIN_Q    = 20995;           // 1/K in Q15, K from the quantised tangents
    localparam int LAT       = N_ROT + 3;       // fold + rotations + scale + log

    localparam logic signed [IN_W-1:0] IN_MIN = {1'b1, {(IN_W-1){1'b0}}};

    // Tangent of each rotation angle in Q(TAN_FRAC).
    function automatic int tan_q(input int k);
        case (k)
            0:       return 1 << TAN_FRAC;
            1:       return 424;
            default: return 204;
        endcase
    endfunction

    // Upper tangent bound (Q10) of the residual angle after each stage.
    function automatic int bound_q(input int k);
        case (k)
            0:       return 1040;
            1:       return 430;
            default: return 210;
        endcase
    endfunction

    typedef struct packed {
        logic                 vld;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
    } vec_t;

    typedef struct packed {
        logic             vld;
        logic [MAG_W-1:0] mag;
    } mag_t;

    typedef struct packed {
        logic              vld;
        logic [MAG_W-1:0]  mag;
        logic [CODE_W-1:0] code;
    } res_t;

endpackage

// File: rtl/magcomp_fold.sv
module magcomp_fold
    import magcomp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   in_vld,
    input  logic signed [IN_W-1:0] re,
    input  logic signed [IN_W-1:0] im,
    output vec_t                   o
);

    localparam int PAD = IW - IN_W - GUARD + 1;

    vec_t st_d, st_q;

    function automatic logic [IN_W-2:0] sat_abs(input logic signed [IN_W-1:0] v);
        logic signed [IN_W-1:0] n;
        n = -v;
        if (v == IN_MIN)
            return {(IN_W-1){1'b1}};
        else if (v[IN_W-1])
            return n[IN_W-2:0];
        else
            return v[IN_W-2:0];
    endfunction

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.vld = in_vld;
            st_d.x   = $signed({{PAD{1'b0}}, sat_abs(re), {GUARD{1'b0}}});
            st_d.y   = $signed({{PAD{1'b0}}, sat_abs(im), {GUARD{1'b0}}});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o = st_q;

    // R1: folded operands are non-negative and never above the saturated full scale
    assert_fold_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.x >= 0 && st_q.y >= 0 &&
                      st_q.x <= $signed(IW'(((1 << (IN_W-1)) - 1) << GUARD)) &&
                      st_q.y <= $signed(IW'(((1 << (IN_W-1)) - 1) << GUARD))));

endmodule

// File: rtl/magcomp_rot.sv
module magcomp_rot
    import magcomp_pkg::*;
#(
    parameter int TAN_Q   = 1024,
    parameter int BOUND_Q = 1040
)(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  vec_t i,
    output vec_t o
);

    localparam int PW = IW + TAN_FRAC + 2;
    localparam logic signed [TAN_FRAC+1:0] TAN_C = (TAN_FRAC+2)'(TAN_Q);

    vec_t st_d, st_q;
    logic signed [PW-1:0] px, py;
    logic signed [IW-1:0] tx, ty;

    always_comb begin
        px = $signed(i.x) * TAN_C;
        py = $signed(i.y) * TAN_C;
        tx = IW'(px >>> TAN_FRAC);
        ty = IW'(py >>> TAN_FRAC);
        st_d = st_q;
        if (en) begin
            st_d.vld = i.vld;
            if (i.y >= 0) begin
                st_d.x = i.x + ty;
                st_d.y = i.y - tx;
            end else begin
                st_d.x = i.x - ty;
                st_d.y = i.y + tx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o = st_q;

    // residual angle bookkeeping for the checks below
    longint ay_l, bx_l;
    always_comb begin
        ay_l = (st_q.y < 0) ? -longint'(st_q.y) : longint'(st_q.y);
        ay_l = ay_l * 1024;
        bx_l = longint'(st_q.x) * BOUND_Q + 16 * 1024;
    end

    // R2: the rotated real part stays positive
    assert_rot_xpos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> st_q.x >= 0);

    // R2: each stage narrows the residual angle toward the real axis
    assert_rot_converge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> ay_l <= bx_l);

endmodule

// File: rtl/magcomp_scale.sv
module magcomp_scale
    import magcomp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  vec_t i,
    output mag_t o
);

    localparam int PW = IW + GAIN_FRAC + 2;
    localparam int SH = GAIN_FRAC + GUARD;
    localparam logic signed [GAIN_FRAC+1:0] GAIN_C = (GAIN_FRAC+2)'(GAIN_Q);
    localparam logic signed [PW-1:0] RND   = PW'(1) <<< (SH - 1);
    localparam logic signed [PW-1:0] MAXV  = (PW'(1) <<< MAG_W) - PW'(1);

    mag_t st_d, st_q;
    logic signed [PW-1:0] prod, rsh;

    always_comb begin
        prod = $signed(i.x) * GAIN_C;
        rsh  = (prod + RND) >>> SH;
        st_d = st_q;
        if (en) begin
            st_d.vld = i.vld;
            if (rsh > MAXV)
                st_d.mag = {MAG_W{1'b1}};
            else if (rsh < 0)
                st_d.mag = '0;
            else
                st_d.mag = rsh[MAG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o = st_q;

    // R2: a clearly non-zero rotated vector never collapses to zero magnitude
    assert_scale_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && i.vld && i.x >= $signed(IW'(64 << GUARD))) |=> (st_q.vld && st_q.mag != 0));

endmodule

// File: rtl/magcomp_log.sv
module magcomp_log
    import magcomp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  mag_t i,
    output res_t o
);

    res_t st_d, st_q;
    logic [POS_W-1:0] pos;
    logic             found;
    logic [MAG_W+1:0] sh;

    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int b = MAG_W - 1; b >= 0; b--) begin
            if (!found && i.mag[b]) begin
                pos   = POS_W'(b);
                found = 1'b1;
            end
        end
        sh   = {i.mag, 2'b00} >> pos;
        st_d = st_q;
        if (en) begin
            st_d.vld  = i.vld;
            st_d.mag  = i.mag;
            st_d.code = found ? {pos, sh[1:0]} : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o = st_q;

    // R4: the exponent field never names a bit above the magnitude width
    assert_log_exp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> st_q.code[CODE_W-1:2] <= POS_W'(MAG_W - 1));

endmodule

// File: rtl/magcomp_top.sv
module magcomp_top
    import magcomp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_re,
    input  logic [15:0]       in_im,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [14:0]       out_mag,
    output logic [5:0]        out_code
);

    vec_t rot_v [N_ROT+1];
    mag_t mag_v;
    res_t res_v;
    logic adv;

    // Whole-pipeline advance: free slot at the end or consumer taking it.
    assign adv = !res_v.vld || out_ready;

    magcomp_fold u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (adv),
        .in_vld (in_valid),
        .re     ($signed(in_re)),
        .im     ($signed(in_im)),
        .o      (rot_v[0])
    );

    for (genvar g = 0; g < N_ROT; g++) begin : g_rot
        magcomp_rot #(
            .TAN_Q   (tan_q(g)),
            .BOUND_Q (bound_q(g))
        ) u_rot (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (adv),
            .i     (rot_v[g]),
            .o     (rot_v[g+1])
        );
    end

    magcomp_scale u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv),
        .i     (rot_v[N_ROT]),
        .o     (mag_v)
    );

    magcomp_log u_log (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv),
        .i     (mag_v),
        .o     (res_v)
    );

    assign in_ready  = adv;
    assign out_valid = res_v.vld;
    assign out_mag   = res_v.mag;
    assign out_code  = res_v.code;

    // R7: a held result does not move or vanish
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mag) && $stable(out_code)));

    // R7: an empty output slot always lets the input through
    assert_ready_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R7: a stalled output blocks the input
    assert_block_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R5: a zero magnitude is reported with the zero code
    assert_zero_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mag == '0) |-> out_code == '0);

endmodule

// File: tb/sim_magcomp_top.sv
`timescale 1ns/1ps
module sim_magcomp_top;

    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_re = '0;
    logic [15:0] in_im = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [14:0] out_mag;
    logic [5:0]  out_code;

    int nchk = 0;
    int nerr = 0;
    int acc_cnt = 0;
    int out_cnt = 0;
    int cyc = 0;
    logic [31:0] exp_q[$];
    int got_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    magcomp_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
        .out_mag(out_mag), .out_code(out_code)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    function automatic int fold_abs(input logic [15:0] v);
        int s;
        s = $signed(v);
        if (s == -32768) return 32767;
        return (s < 0) ? -s : s;
    endfunction

    function automatic int log_code(input int m);
        int p;
        if (m == 0) return 0;
        p = 0;
        for (int b = 0; b < 15; b++) if ((m >> b) & 1) p = b;
        return 4 * p + (((m << 2) >> p) & 3);
    endfunction

    task automatic check_item(input logic [15:0] re, input logic [15:0] im, input int m, input int c);
        real t;
        int lo, hi, a, b;
        a = fold_abs(re);
        b = fold_abs(im);
        t = $sqrt(real'(a) * real'(a) + real'(b) * real'(b));
        lo = int'($floor(t * 0.975)) - 3;
        hi = int'($ceil(t * 1.005)) + 3;
        if (a == 0 && b == 0)
            chk(m == 0, "R5", "zero vector magnitude", m, 0);
        else if (lo > 32767)
            chk(m == 32767, "R3", "saturated magnitude", m, 32767);
        else
            chk(m >= lo && m <= hi, "R2", $sformatf("magnitude of (%0d,%0d) upper=%0d", $signed(re), $signed(im), hi), m, lo);
        chk(c == log_code(m), "R4", "log code", c, log_code(m));
    endtask

    // Scoreboard: samples at the falling edge, between driver updates.
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_valid && in_ready) begin
                exp_q.push_back({in_re, in_im});
                acc_cnt++;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "output without input", out_mag, -1);
                end else begin
                    logic [31:0] it;
                    it = exp_q.pop_front();
                    check_item(it[31:16], it[15:0], out_mag, out_code);
                end
                got_q.push_back(out_mag);
                out_cnt++;
            end
        end
    end

    // Drive a bin and wait for it to be taken; returns just after the taking edge.
    task automatic send(input int re, input int im);
        in_valid = 1'b1;
        in_re    = 16'(re);
        in_im    = 16'(im);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int t;
        out_ready = 1'b1;
        t = 0;
        while (exp_q.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, "R7", "pending bins after drain", exp_q.size(), 0);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
        @(posedge clk);
        #1;
    endtask

    task automatic t_patterns();
        send(0, 0);
        send(1, 0);
        send(100, 0);
        send(0, -100);
        send(3000, 4000);
        send(-3000, 4000);
        send(-20000, -15000);
        send(12345, -6789);
        send(1, 1);
        send(7, -3);
        for (int k = 0; k < 52; k++) begin
            real ang;
            ang = real'(k) * 7.0 * 3.14159265358979 / 180.0;
            send(int'(20000.0 * $cos(ang)), int'(20000.0 * $sin(ang)));
        end
        idle();
        drain();
    endtask

    task automatic t_saturate();
        got_q.delete();
        send(-32768, 0);
        send(32767, 0);
        send(0, -32768);
        send(32767, 32767);
        send(-32768, -32768);
        send(-1234, 5678);
        send(1234, -5678);
        idle();
        drain();
        chk(got_q.size() == 7, "R1", "saturation results count", got_q.size(), 7);
        if (got_q.size() == 7) begin
            chk(got_q[0] == got_q[1], "R1", "-32768 folded like 32767", got_q[0], got_q[1]);
            chk(got_q[2] == got_q[1], "R1", "imaginary -32768 folded", got_q[2], got_q[1]);
            chk(got_q[3] == 32767, "R3", "full-scale diagonal", got_q[3], 32767);
            chk(got_q[4] == 32767, "R3", "most-negative diagonal", got_q[4], 32767);
            chk(got_q[5] == got_q[6], "R1", "sign independence", got_q[5], got_q[6]);
        end
    endtask

    task automatic t_latency();
        int n;
        out_ready = 1'b1;
        send(5000, -2500);
        idle();
        n = 1;
        @(negedge clk);
        while (!out_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == LAT, "R6", "edges until output valid", n, LAT);
        drain();
        // back-to-back acceptance on consecutive edges
        begin
            int c0;
            c0 = cyc;
            for (int k = 0; k < 8; k++) send(1000 * k, 500);
            idle();
            chk(cyc - c0 == 8, "R6", "cycles for 8 back-to-back bins", cyc - c0, 8);
        end
        drain();
    endtask

    task automatic t_stall();
        int a0;
        logic [14:0] m0;
        logic [5:0]  c0;
        out_ready = 1'b0;
        a0 = acc_cnt;
        in_valid = 1'b1;
        for (int k = 0; k < 12; k++) begin
            in_re = 16'(1500 * (k + 1));
            in_im = 16'(-700 * k);
            @(posedge clk);
            #1;
        end
        @(negedge clk);
        chk(acc_cnt - a0 == LAT, "R7", "bins taken into a stalled pipeline", acc_cnt - a0, LAT);
        chk(in_ready == 1'b0, "R7", "in_ready while stalled", in_ready, 0);
        chk(out_valid == 1'b1, "R7", "out_valid while stalled", out_valid, 1);
        m0 = out_mag;
        c0 = out_code;
        repeat (5) @(negedge clk);
        chk(out_mag == m0, "R7", "held magnitude", out_mag, m0);
        chk(out_code == c0, "R7", "held code", out_code, c0);
        chk(acc_cnt - a0 == LAT, "R7", "no bin taken while stalled", acc_cnt - a0, LAT);
        @(posedge clk);
        #1;
        idle();
        drain();
        // irregular consumer over a longer stream
        fork
            begin
                for (int k = 0; k < 40; k++) send(800 * k - 16000, 12000 - 600 * k);
                idle();
            end
            begin
                for (int k = 0; k < 150; k++) begin
                    out_ready = ((k % 3) != 0) && ((k % 7) != 2);
                    @(posedge clk);
                    #1;
                end
            end
        join
        drain();
        chk(out_cnt == acc_cnt, "R7", "outputs equal inputs", out_cnt, acc_cnt);
    endtask

    task automatic t_frame();
        int c0, o0;
        out_ready = 1'b1;
        o0 = out_cnt;
        c0 = cyc;
        for (int k = 0; k < 256; k++) send((k * 97) % 30000 - 15000, (k * 53) % 20000 - 10000);
        idle();
        while (out_cnt - o0 < 256 && cyc - c0 < 2000) @(negedge clk);
        chk(out_cnt - o0 == 256, "R9", "frame results delivered", out_cnt - o0, 256);
        chk(cyc - c0 <= 256 + LAT, "R9", "frame cycles", cyc - c0, 256 + LAT);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_patterns();
        t_saturate();
        t_latency();
        t_stall();
        t_frame();
        summary();
        $finish;
    end

endmodule